// File: doc/BRIEF.md
# NAND Page Program Sequencer with Column Jumps

This block is the host side of an 8-bit NAND bus. It programs one page whose payload is spread over several separate column ranges. A request names the destination row, how many segments follow, the confirm style and an address-to-data settle count in clocks. Each segment descriptor gives a start column, a byte count and, if wanted, a new destination row. Data bytes come from a valid/ready stream.

The first segment opens the page with the program-setup command, two column bytes and three row bytes. Every later segment starts with the column-change command and two column bytes. If that segment changes the destination, three row bytes follow the column bytes. After the last address byte of any segment, the bus stays quiet for at least the programmed settle count before the first data byte goes out. After the final segment the sequencer issues the confirm command, waits for the device to go busy and then ready again, and pulses done.

Each bus cycle lasts one clock, with `nand_we` high:
- `nand_cle` high marks a command byte.
- `nand_ale` high marks an address byte.
- Neither high marks a data byte.

Top module: `nand_prog_seq`

## Requirements
- R1: After synchronous reset `req_ready` is 1, and `nand_we`, `nand_cle`, `nand_ale`, `seg_ready`, `din_ready` and `done` are all 0.
- R2: The first segment produces command 80h, then five address bytes in this order: column low, column high, row bits 7:0, row bits 15:8, row bits 23:16. The row is the one given in the request.
- R3: Each later segment without a destination change produces command 85h, then column low and column high.
- R4: A later segment with `seg_retarget`=1 produces 85h, column low, column high, then the new row bytes from low to high.
- R5: Between the last address strobe of a segment and its first data strobe there are at least `req_adl` clocks with no strobe.
- R6: A segment sends exactly `seg_len` data bytes, taken from the stream in order. Each data strobe carries the byte accepted by the `din_valid`/`din_ready` handshake one clock earlier.
- R7: A segment with `seg_len`=0 still sends its command and address bytes, but sends no data. The next command or the confirm follows it.
- R8: Commands 80h and 85h are strobed only when `nand_rdy` was 1 two clocks earlier. While `nand_rdy` stays 0, no segment command goes out.
- R9: After the last segment the confirm byte is 10h when `req_cache`=0 and 15h when `req_cache`=1.
- R10: After the confirm, `done` pulses for exactly one clock. This happens after `nand_rdy` has gone low and then been seen high again. `req_ready` returns to 1 afterwards.
- R11: `nand_cle` and `nand_ale` are never high together, and neither is high without `nand_we`.
- R12: The `seg_retarget` flag of the first segment has no effect. The first segment always carries the request row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Sequencer idle, accepts a request |
| req_row | input | ROW_W | Destination row |
| req_nseg_m1 | input | NSEG_W | Segment count minus one |
| req_cache | input | 1 | 1 selects the cache confirm (15h) |
| req_adl | input | ADL_W | Address-to-data settle clocks |
| seg_valid | input | 1 | Segment descriptor present |
| seg_ready | output | 1 | Descriptor accepted this clock |
| seg_col | input | COL_W | Segment start column |
| seg_len | input | LEN_W | Segment byte count |
| seg_retarget | input | 1 | Change destination row (ignored on first segment) |
| seg_row | input | ROW_W | New destination row |
| din_valid | input | 1 | Data byte present |
| din_ready | output | 1 | Data byte taken this clock |
| din_data | input | 8 | Data byte |
| nand_rdy | input | 1 | Device ready |
| nand_io | output | 8 | Bus byte |
| nand_cle | output | 1 | Command strobe qualifier |
| nand_ale | output | 1 | Address strobe qualifier |
| nand_we | output | 1 | Bus cycle strobe |
| done | output | 1 | One-clock completion pulse |

## Verification
Every strobe is registered, so a byte appears on the bus one clock after the state or stream handshake that produced it. A segment command appears two clocks after the `nand_rdy` sample that released it. The bench therefore records each strobe with its clock number at the falling edge, and compares the whole list against one built from the request. It checks the settle gap as the difference between the stamps of the last address strobe and the first data strobe. It checks the stalled start against the clock in which ready rose plus three. `done` is counted over the whole run, which tolerates the variable busy time.

// File: rtl/nps_pkg.sv
package nps_pkg;
  localparam logic [7:0] OP_PROG_SETUP = 8'h80;
  localparam logic [7:0] OP_COL_JUMP   = 8'h85;
  localparam logic [7:0] OP_CONFIRM    = 8'h10;
  localparam logic [7:0] OP_CONF_CACHE = 8'h15;

  typedef enum logic [3:0] {
    ST_IDLE, ST_GET, ST_WAITR, ST_CMD, ST_ADDR, ST_SETTLE,
    ST_DATA, ST_NEXT, ST_CONF, ST_BUSY, ST_FINISH
  } seq_state_t;

  typedef struct packed {
    logic       we;
    logic       cle;
    logic       ale;
    logic [7:0] io;
  } bus_cycle_t;
endpackage

// File: rtl/nps_addr_mux.sv
module nps_addr_mux #(
  parameter int COL_W = 16,
  parameter int ROW_W = 24,
  parameter int IDX_W = 3
) (
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       byte_o
);
  localparam int NBYTES = (COL_W + ROW_W) / 8;

  logic [COL_W+ROW_W-1:0] packed_addr;
  logic [7:0] lanes [NBYTES];

  assign packed_addr = {row, col};

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lanes[g] = packed_addr[g*8 +: 8];
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < NBYTES; k++)
      if (idx == IDX_W'(k)) byte_o = lanes[k];
  end
endmodule

// File: rtl/nps_settle_timer.sv
module nps_settle_timer #(
  parameter int ADL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ADL_W-1:0] count,
  input  logic             run,
  output logic             expired
);
  logic [ADL_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= count;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  assert_load_takes_count_R5: assert property (@(posedge clk) disable iff (rst)
    (load && count != '0) |=> !expired);
endmodule

// File: rtl/nps_bus_reg.sv
module nps_bus_reg
  import nps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bus_cycle_t nxt,
  output bus_cycle_t cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end
endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq
  import nps_pkg::*;
#(
  parameter int COL_W  = 16,
  parameter int ROW_W  = 24,
  parameter int LEN_W  = 12,
  parameter int ADL_W  = 8,
  parameter int NSEG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [NSEG_W-1:0] req_nseg_m1,
  input  logic              req_cache,
  input  logic [ADL_W-1:0]  req_adl,
  input  logic              seg_valid,
  output logic              seg_ready,
  input  logic [COL_W-1:0]  seg_col,
  input  logic [LEN_W-1:0]  seg_len,
  input  logic              seg_retarget,
  input  logic [ROW_W-1:0]  seg_row,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [7:0]        din_data,
  input  logic              nand_rdy,
  output logic [7:0]        nand_io,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we,
  output logic              done
);
  localparam int COL_BYTES  = COL_W / 8;
  localparam int ROW_BYTES  = ROW_W / 8;
  localparam int ADDR_BYTES = COL_BYTES + ROW_BYTES;
  localparam int IDX_W      = $clog2(ADDR_BYTES);
  localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(ADDR_BYTES - 1);
  localparam logic [IDX_W-1:0] LAST_COL  = IDX_W'(COL_BYTES - 1);

  seq_state_t        st_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [LEN_W-1:0]  len_left;
  logic [NSEG_W-1:0] seg_left;
  logic [ADL_W-1:0]  adl_q;
  logic              cache_q, first_q, rt_q, done_q;
  logic [IDX_W-1:0]  addr_idx, addr_last;
  logic [7:0]        addr_byte;
  logic              tmr_load, tmr_expired, fire;
  bus_cycle_t        bus_nxt, bus_cur;

  nps_addr_mux #(.COL_W(COL_W), .ROW_W(ROW_W), .IDX_W(IDX_W)) u_amux (
    .col(col_q), .row(row_q), .idx(addr_idx), .byte_o(addr_byte));

  nps_settle_timer #(.ADL_W(ADL_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .count(adl_q),
    .run(st_q == ST_SETTLE), .expired(tmr_expired));

  nps_bus_reg u_bus (.clk(clk), .rst(rst), .nxt(bus_nxt), .cur(bus_cur));

  assign req_ready = (st_q == ST_IDLE);
  assign seg_ready = (st_q == ST_GET);
  assign din_ready = (st_q == ST_DATA);
  assign fire      = din_valid && din_ready;

  always_comb begin
    bus_nxt  = '0;
    tmr_load = 1'b0;
    case (st_q)
      ST_CMD: begin
        bus_nxt.we  = 1'b1;
        bus_nxt.cle = 1'b1;
        bus_nxt.io  = first_q ? OP_PROG_SETUP : OP_COL_JUMP;
      end
      ST_ADDR: begin
        bus_nxt.we  = 1'b1;
        bus_nxt.ale = 1'b1;
        bus_nxt.io  = addr_byte;
        tmr_load    = (addr_idx == addr_last);
      end
      ST_DATA: begin
        bus_nxt.we = fire;
        bus_nxt.io = fire ? din_data : 8'h00;
      end
      ST_CONF: begin
        bus_nxt.we  = 1'b1;
        bus_nxt.cle = 1'b1;
        bus_nxt.io  = cache_q ? OP_CONF_CACHE : OP_CONFIRM;
      end
      default: bus_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      row_q     <= '0;
      col_q     <= '0;
      len_left  <= '0;
      seg_left  <= '0;
      adl_q     <= '0;
      cache_q   <= 1'b0;
      first_q   <= 1'b0;
      rt_q      <= 1'b0;
      done_q    <= 1'b0;
      addr_idx  <= '0;
      addr_last <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          row_q    <= req_row;
          seg_left <= req_nseg_m1;
          cache_q  <= req_cache;
          adl_q    <= req_adl;
          first_q  <= 1'b1;
          st_q     <= ST_GET;
        end
        ST_GET: if (seg_valid) begin
          col_q    <= seg_col;
          len_left <= seg_len;
          rt_q     <= !first_q && seg_retarget;
          if (!first_q && seg_retarget) row_q <= seg_row;
          st_q     <= ST_WAITR;
        end
        ST_WAITR: if (nand_rdy) st_q <= ST_CMD;
        ST_CMD: begin
          addr_idx  <= '0;
          addr_last <= (first_q || rt_q) ? LAST_FULL : LAST_COL;
          st_q      <= ST_ADDR;
        end
        ST_ADDR: begin
          if (addr_idx == addr_last) st_q <= ST_SETTLE;
          else                       addr_idx <= addr_idx + 1'b1;
        end
        ST_SETTLE: if (tmr_expired) st_q <= (len_left == '0) ? ST_NEXT : ST_DATA;
        ST_DATA: if (fire) begin
          len_left <= len_left - 1'b1;
          if (len_left == LEN_W'(1)) st_q <= ST_NEXT;
        end
        ST_NEXT: begin
          first_q <= 1'b0;
          if (seg_left == '0) st_q <= ST_CONF;
          else begin
            seg_left <= seg_left - 1'b1;
            st_q     <= ST_GET;
          end
        end
        ST_CONF:  st_q <= ST_BUSY;
        ST_BUSY:  if (!nand_rdy) st_q <= ST_FINISH;
        ST_FINISH: if (nand_rdy) begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign nand_we  = bus_cur.we;
  assign nand_cle = bus_cur.cle;
  assign nand_ale = bus_cur.ale;
  assign nand_io  = bus_cur.io;
  assign done     = done_q;

  // Observation of the settle gap at the bus, relative to the last address strobe
  logic             data_strobe;
  logic             gap_pend;
  logic [ADL_W:0]   gap_cnt;
  assign data_strobe = nand_we && !nand_cle && !nand_ale;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_pend <= 1'b0;
      gap_cnt  <= '0;
    end else if (nand_we && nand_ale) begin
      gap_pend <= 1'b1;
      gap_cnt  <= '0;
    end else begin
      if (data_strobe) gap_pend <= 1'b0;
      if (!nand_we && gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assert_settle_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (data_strobe && gap_pend) |-> (gap_cnt >= {1'b0, adl_q}));

  assert_data_from_stream_R6: assert property (@(posedge clk) disable iff (rst)
    data_strobe |-> ($past(din_valid && din_ready) && nand_io == $past(din_data)));

  assert_segcmd_after_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (nand_we && nand_cle && (nand_io == OP_COL_JUMP || nand_io == OP_PROG_SETUP))
      |-> $past(nand_rdy, 2));

  assert_done_on_ready_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(nand_rdy) && !$past(done)));

  assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale) && ((nand_cle || nand_ale) -> nand_we));
endmodule

// File: tb/tb_nand_prog_seq.sv
`timescale 1ns/1ps
module tb_nand_prog_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_ready, req_cache = 1'b0;
  logic [23:0] req_row = '0;
  logic [3:0]  req_nseg_m1 = '0;
  logic [7:0]  req_adl = '0;
  logic        seg_valid, seg_ready, seg_retarget;
  logic [15:0] seg_col;
  logic [11:0] seg_len;
  logic [23:0] seg_row;
  logic        din_valid, din_ready;
  logic [7:0]  din_data;
  logic        nand_rdy = 1'b1;
  logic [7:0]  nand_io;
  logic        nand_cle, nand_ale, nand_we, done;

  nand_prog_seq dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_nseg_m1(req_nseg_m1), .req_cache(req_cache), .req_adl(req_adl),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_col(seg_col), .seg_len(seg_len),
    .seg_retarget(seg_retarget), .seg_row(seg_row), .din_valid(din_valid),
    .din_ready(din_ready), .din_data(din_data), .nand_rdy(nand_rdy), .nand_io(nand_io),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we(nand_we), .done(done));

  int checks = 0, errors = 0, cyc = 0;

  // segment table and stream state
  logic [15:0] s_col [8];
  logic [11:0] s_len [8];
  logic        s_rt  [8];
  logic [23:0] s_row [8];
  int   nsm1 = 0, sidx = 0, didx = 0, dseed = 0;
  bit   running = 0, clr = 0, stall_en = 0, stall = 0, ext_low = 0;
  int   busy_cnt = 0;

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed + i * 37);
  endfunction

  assign seg_valid    = running && (sidx <= nsm1);
  assign seg_col      = s_col[sidx % 8];
  assign seg_len      = s_len[sidx % 8];
  assign seg_retarget = s_rt[sidx % 8];
  assign seg_row      = s_row[sidx % 8];
  assign din_valid    = running && !stall;
  assign din_data     = pat(dseed, didx);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr) begin sidx <= 0; didx <= 0; end
    else begin
      if (seg_valid && seg_ready) sidx <= sidx + 1;
      if (din_valid && din_ready) didx <= didx + 1;
    end
    stall <= stall_en && (($urandom % 4) == 0);
    // device ready model: busy after a confirm, or held low by the bench
    if (nand_we && nand_cle && (nand_io == 8'h10 || nand_io == 8'h15))
      busy_cnt <= 3 + int'($urandom % 6);
    else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    nand_rdy <= (busy_cnt == 0) && !ext_low &&
                !(nand_we && nand_cle && (nand_io == 8'h10 || nand_io == 8'h15));
  end

  // bus monitor
  int ev_kind [512];
  int ev_byte [512];
  int ev_cyc  [512];
  int ev_n = 0, done_cnt = 0, done_bad = 0, both_err = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (nand_we && ev_n < 512) begin
        ev_kind[ev_n] = nand_cle ? 0 : (nand_ale ? 1 : 2);
        ev_byte[ev_n] = int'(nand_io);
        ev_cyc[ev_n]  = cyc;
        ev_n++;
      end
      if ((nand_cle && nand_ale) || ((nand_cle || nand_ale) && !nand_we)) both_err++;
      if (done) begin done_cnt++; if (!nand_rdy) done_bad++; end
    end
  end

  // expected event list
  int x_kind [512];
  int x_byte [512];
  int x_tag  [512];
  int x_n = 0;

  task automatic push(int k, int b, int t);
    x_kind[x_n] = k; x_byte[x_n] = b; x_tag[x_n] = t; x_n++;
  endtask

  task automatic build_exp(logic [23:0] row, bit cache);
    int d = 0;
    x_n = 0;
    for (int i = 0; i <= nsm1; i++) begin
      if (i == 0) begin
        push(0, 8'h80, 2);                       // R2 setup command
        push(1, int'(s_col[0][7:0]), 2);
        push(1, int'(s_col[0][15:8]), 2);
        push(1, int'(row[7:0]), 12);             // R12 request row despite flag
        push(1, int'(row[15:8]), 12);
        push(1, int'(row[23:16]), 12);
      end else begin
        push(0, 8'h85, 3);                       // R3 column jump
        push(1, int'(s_col[i][7:0]), 3);
        push(1, int'(s_col[i][15:8]), 3);
        if (s_rt[i]) begin                       // R4 new destination
          push(1, int'(s_row[i][7:0]), 4);
          push(1, int'(s_row[i][15:8]), 4);
          push(1, int'(s_row[i][23:16]), 4);
        end
      end
      for (int j = 0; j < int'(s_len[i]); j++) begin
        push(2, int'(pat(dseed, d)), 6);         // R6 stream order
        d++;
      end
    end
    push(0, cache ? 8'h15 : 8'h10, 9);           // R9 confirm type
  endtask

  task automatic chk(bit ok, int tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_prog(logic [23:0] row, bit cache, int adl, bit stall_on, int hold);
    int rise = 0, w = 0, n = 0;
    dseed = int'($urandom % 256);
    build_exp(row, cache);
    @(negedge clk);
    clr = 1; running = 0;
    @(negedge clk);
    clr = 0; ev_n = 0; done_cnt = 0; done_bad = 0; both_err = 0;
    stall_en = stall_on;
    if (hold > 0) ext_low = 1;
    req_row = row; req_cache = cache; req_adl = 8'(adl); req_nseg_m1 = 4'(nsm1);
    running = 1; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(ev_n == 0, 8, "strobes while not ready", ev_n, 0);   // R8
      rise = cyc;
      ext_low = 0;
    end
    while (done_cnt == 0 && w < 5000) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
    running = 0; stall_en = 0;
    chk(done_cnt == 1, 10, "done pulses", done_cnt, 1);         // R10
    chk(done_bad == 0, 10, "done without ready", done_bad, 0);
    chk(req_ready == 1'b1, 10, "req_ready after done", int'(req_ready), 1);
    chk(both_err == 0, 11, "strobe qualifier violations", both_err, 0); // R11
    chk(ev_n == x_n, 7, "bus cycle count", ev_n, x_n);          // R7 and R6 totals
    n = (ev_n < x_n) ? ev_n : x_n;
    for (int k = 0; k < n; k++) begin
      chk(ev_kind[k] == x_kind[k] && ev_byte[k] == x_byte[k], x_tag[k],
          $sformatf("cycle %0d kind/byte", k),
          ev_kind[k] * 256 + ev_byte[k], x_kind[k] * 256 + x_byte[k]);
      if (k > 0 && x_kind[k] == 2 && x_kind[k-1] == 1)           // R5 settle gap
        chk(ev_cyc[k] - ev_cyc[k-1] - 1 >= adl, 5, "settle gap",
            ev_cyc[k] - ev_cyc[k-1] - 1, adl);
    end
    if (hold > 0 && ev_n > 0)                                    // R8 ready gate
      chk(ev_cyc[0] >= rise + 3, 8, "first command clock", ev_cyc[0], rise + 3);
  endtask

  task automatic set_seg(int i, int col, int len, bit rt, int row);
    s_col[i] = 16'(col); s_len[i] = 12'(len); s_rt[i] = rt; s_row[i] = 24'(row);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 8; i++) set_seg(i, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, 1, "req_ready", int'(req_ready), 1);
    chk({nand_we, nand_cle, nand_ale} == 3'b000, 1, "strobes", int'({nand_we, nand_cle, nand_ale}), 0);
    chk({seg_ready, din_ready, done} == 3'b000, 1, "ready/done", int'({seg_ready, din_ready, done}), 0);

    // single segment, plain confirm (R2, R6, R9)
    nsm1 = 0; set_seg(0, 16'h1234, 4, 0, 0);
    run_prog(24'hABCDEF, 0, 3, 0, 0);
    // start held off by ready low, cache confirm (R8, R9)
    nsm1 = 1; set_seg(0, 16'h0010, 2, 0, 0); set_seg(1, 16'h0800, 3, 0, 0);
    run_prog(24'h000102, 1, 2, 0, 12);
    // zero-length segments in the middle and at the end (R7)
    nsm1 = 2; set_seg(0, 16'h0000, 3, 0, 0); set_seg(1, 16'h0200, 0, 0, 0); set_seg(2, 16'h0300, 0, 0, 0);
    run_prog(24'h123456, 0, 1, 1, 0);
    // first-segment flag ignored, later retargets (R12, R4, R3)
    nsm1 = 2; set_seg(0, 16'h0040, 2, 1, 24'h777777); set_seg(1, 16'h0100, 2, 1, 24'h9A8B7C);
    set_seg(2, 16'h0180, 1, 0, 24'h111111);
    run_prog(24'h010203, 1, 4, 0, 0);
    // settle extremes (R5)
    nsm1 = 0; set_seg(0, 16'h0005, 2, 0, 0);
    run_prog(24'h0A0B0C, 0, 0, 0, 0);
    run_prog(24'h0A0B0C, 0, 20, 1, 0);

    // constrained random programs
    for (int t = 0; t < 25; t++) begin
      nsm1 = int'($urandom % 4);
      for (int i = 0; i <= nsm1; i++)
        set_seg(i, int'($urandom % 65536), (($urandom % 5) == 0) ? 0 : int'($urandom % 12),
                bit'($urandom % 2), int'($urandom % 16777216));
      run_prog(24'($urandom), bit'($urandom % 2), int'($urandom % 8), bit'($urandom % 2),
               (($urandom % 4) == 0) ? 5 : 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected < 150000 clocks", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule